// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block runs the source side of DisplayPort link training as a fixed series of abstract commands. After a start pulse it opens the clock-recovery phase, loops on status reads while it adjusts one shared drive setting, then runs channel equalisation. The finish phase always runs, whether training passed or failed. Each step is issued as a single command (select pattern, write drive setting, read link status, wait, signal training complete). An outside agent carries out the command and acknowledges it. For a status read, that agent also returns the sink's per-lane flags and adjust requests.

The drive setting is one byte, and the same value is applied to every lane. Each time the sink asks for an adjustment, the block takes the largest voltage-swing level and the largest pre-emphasis level requested by any active lane. Swing levels 0..3 stand for 0.4, 0.6, 0.8 and 1.2 V. Pre-emphasis levels 0..3 stand for 0, 3.5, 6 and 9.5 dB. At the end of a run the block raises a one-cycle done pulse together with a pass flag.

Top module: `dp_link_trainer`

## Requirements
- R1: After reset and with no start pulse, `cmdValid` and `done` stay low.
- R2: A start pulse issues, in order: pattern select with argument 1, a drive write with argument 0, and a wait with argument 0 (long settle). Each clock-recovery iteration then issues a wait with argument 1 followed by a status read.
- R3: `laneCount` 0, 1 and 2 select 1, 2 and 4 active lanes, and 3 selects 4 lanes. Clock recovery succeeds when `stsCrOk` is set on every active lane. Bits of inactive lanes are ignored.
- R4: An adjust merges the requests of the active lanes only. The swing request of lane i is at bits [2i+1:2i] of `stsSwing`, and its pre-emphasis request is at the same bits of `stsPreEmph`. The drive byte is laid out as: [1:0] maximum swing, [2] set when that swing is 3, [4:3] maximum pre-emphasis, [5] set when that pre-emphasis is 3. The new drive setting is then written.
- R5: Clock recovery fails if the current drive setting already carries the swing-limit flag when a status read is not successful.
- R6: Clock recovery keeps a repeat counter. It counts up when the current swing equals the swing of the previous iteration and clears otherwise. The stored swing starts at a value no lane can request. The phase fails when the counter reaches 5.
- R7: Equalisation issues pattern select with argument 3 when `tp3Ok` is high and 2 otherwise. Each iteration is a wait with argument 2 followed by a status read. The phase succeeds when `stsEqOk` is set on every active lane, and it keeps the drive setting left by clock recovery.
- R8: Equalisation counts its adjusts and fails at the first unsuccessful read after six adjusts, which is the seventh read.
- R9: A status read returned with `stsErr` high ends the current phase as a failure. If clock recovery has not succeeded, equalisation is skipped.
- R10: Every run ends with a wait with argument 0, pattern select with argument 0 and a complete command. A one-cycle `done` pulse follows with no command in flight, and `pass` is high only if both phases succeeded.
- R11: Op codes are: 1 pattern, 2 drive write, 3 status read, 4 wait, 5 complete. Status reads and complete carry argument 0. A command holds `cmdOp` and `cmdArg` stable until the cycle in which `cmdDone` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a training run (sampled when idle) |
| laneCount | input | 2 | Active lane code: 0=1, 1=2, 2 or 3=4 lanes |
| tp3Ok | input | 1 | Sink supports training pattern 3 |
| cmdValid | output | 1 | A command is pending |
| cmdOp | output | 3 | Command op code |
| cmdArg | output | 8 | Command argument (pattern, drive byte or wait kind) |
| cmdDone | input | 1 | Current command finished; status inputs valid for a read |
| stsErr | input | 1 | Status read failed |
| stsCrOk | input | 4 | Per-lane clock-recovery-ok |
| stsEqOk | input | 4 | Per-lane channel-equalisation-ok |
| stsSwing | input | 8 | Per-lane requested swing level, 2 bits per lane |
| stsPreEmph | input | 8 | Per-lane requested pre-emphasis level, 2 bits per lane |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the run, valid with done |

## Verification
The bench scores the full command stream of each run against a model built from the requirements. The runs are:
- a four-lane run that succeeds at once, which checks the basic order and pattern 3;
- a two-lane run whose status words carry large requests and set flags on inactive lanes, which separates correct lane masking from merging every lane;
- a one-lane run that reaches the swing limit;
- a run with a constant request that must stop on the seventh read of the repeat rule;
- an equalisation run that never settles, which checks the adjust limit;
- status errors in each phase.

The failure runs show that finish still runs and that `pass` stays low, and the error runs show that equalisation is skipped after a failed clock recovery.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int ARG_W = 8;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_PATTERN  = 3'd1,
    OP_DRIVE    = 3'd2,
    OP_STATUS   = 3'd3,
    OP_WAIT     = 3'd4,
    OP_COMPLETE = 3'd5
  } op_e;

  localparam logic [ARG_W-1:0] WAIT_LONG = 8'd0;
  localparam logic [ARG_W-1:0] WAIT_CR   = 8'd1;
  localparam logic [ARG_W-1:0] WAIT_EQ   = 8'd2;

  typedef struct packed {
    logic clrDrive;
    logic loadMerged;
    logic clrTries;
    logic incTries;
    logic initPrev;
    logic savePrev;
  } strobe_t;
endpackage

// File: rtl/lt_merge.sv
module lt_merge #(
  parameter int LANES = 4,
  parameter int LVL_W = 2,
  localparam int DRV_W = 2 * LVL_W + 2
) (
  input  logic [LANES-1:0]       laneMask,
  input  logic [LANES*LVL_W-1:0] swingReq,
  input  logic [LANES*LVL_W-1:0] preReq,
  output logic [DRV_W-1:0]       merged
);
  logic [LVL_W-1:0] vMax;
  logic [LVL_W-1:0] pMax;

  always_comb begin
    vMax = '0;
    pMax = '0;
    for (int i = 0; i < LANES; i++) begin
      if (laneMask[i]) begin
        if (swingReq[i*LVL_W +: LVL_W] > vMax) vMax = swingReq[i*LVL_W +: LVL_W];
        if (preReq[i*LVL_W +: LVL_W] > pMax)   pMax = preReq[i*LVL_W +: LVL_W];
      end
    end
  end

  // top level of each field raises its limit flag
  assign merged = {&pMax, pMax, &vMax, vMax};
endmodule

// File: rtl/lt_datapath.sv
module lt_datapath
  import lt_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LVL_W = 2,
  parameter int TRY_W = 3,
  parameter int EQ_TRY_LIMIT = 5,
  localparam int DRV_W = 2 * LVL_W + 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                st,
  input  logic [1:0]             laneCount,
  input  logic [LANES-1:0]       stsCrOk,
  input  logic [LANES-1:0]       stsEqOk,
  input  logic [LANES*LVL_W-1:0] stsSwing,
  input  logic [LANES*LVL_W-1:0] stsPreEmph,
  output logic [DRV_W-1:0]       drive,
  output logic                   crAll,
  output logic                   eqAll,
  output logic                   atMaxSwing,
  output logic                   sameVolt,
  output logic [TRY_W-1:0]       tries
);
  localparam logic [LVL_W:0] NO_VOLT = {1'b1, {LVL_W{1'b0}}};

  logic [LANES-1:0] laneMask;
  logic [DRV_W-1:0] merged;
  logic [LVL_W:0]   prevVolt;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign laneMask[g] = (32'(g) < (32'd1 << laneCount));
  end

  lt_merge #(.LANES(LANES), .LVL_W(LVL_W)) i_merge (
    .laneMask(laneMask),
    .swingReq(stsSwing),
    .preReq  (stsPreEmph),
    .merged  (merged)
  );

  assign crAll      = &(stsCrOk | ~laneMask);
  assign eqAll      = &(stsEqOk | ~laneMask);
  assign atMaxSwing = drive[LVL_W];
  assign sameVolt   = ({1'b0, drive[LVL_W-1:0]} == prevVolt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drive    <= '0;
      prevVolt <= NO_VOLT;
      tries    <= '0;
    end else begin
      if (st.clrDrive)        drive <= '0;
      else if (st.loadMerged) drive <= merged;

      if (st.initPrev)      prevVolt <= NO_VOLT;
      else if (st.savePrev) prevVolt <= {1'b0, drive[LVL_W-1:0]};

      if (st.clrTries)      tries <= '0;
      else if (st.incTries) tries <= tries + 1'b1;
    end
  end

  AST_SWING_FLAG_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    drive[LVL_W] |-> &drive[LVL_W-1:0]);  // R4
  AST_TRIES_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    tries <= TRY_W'(EQ_TRY_LIMIT + 1));  // R8
endmodule

// File: rtl/lt_control.sv
module lt_control
  import lt_pkg::*;
#(
  parameter int DRV_W = 6,
  parameter int TRY_W = 3,
  parameter int CR_TRY_LIMIT = 5,
  parameter int EQ_TRY_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             tp3Ok,
  input  logic             cmdDone,
  input  logic             stsErr,
  input  logic             crAll,
  input  logic             eqAll,
  input  logic             atMaxSwing,
  input  logic             sameVolt,
  input  logic [TRY_W-1:0] tries,
  input  logic [DRV_W-1:0] drive,
  output strobe_t          st,
  output logic             cmdValid,
  output logic [2:0]       cmdOp,
  output logic [ARG_W-1:0] cmdArg,
  output logic             done,
  output logic             pass
);
  typedef enum logic [3:0] {
    S_IDLE, S_CR_PAT, S_CR_ZERO, S_CR_SETTLE, S_CR_WAIT, S_CR_READ, S_CR_ADJ,
    S_EQ_PAT, S_EQ_WAIT, S_EQ_READ, S_EQ_ADJ,
    S_FIN_WAIT, S_FIN_PAT, S_FIN_CMP, S_DONE
  } state_e;

  state_e state, nxt;
  logic   passReg, passSet, passClr;
  op_e    op;

  always_comb begin
    nxt      = state;
    st       = '0;
    cmdValid = 1'b0;
    op       = OP_NONE;
    cmdArg   = '0;
    passSet  = 1'b0;
    passClr  = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        nxt = S_CR_PAT;
        st.clrDrive = 1'b1;
        st.clrTries = 1'b1;
        st.initPrev = 1'b1;
        passClr     = 1'b1;
      end
      S_CR_PAT: begin
        cmdValid = 1'b1; op = OP_PATTERN; cmdArg = 8'd1;
        if (cmdDone) nxt = S_CR_ZERO;
      end
      S_CR_ZERO: begin
        cmdValid = 1'b1; op = OP_DRIVE; cmdArg = ARG_W'(drive);
        if (cmdDone) nxt = S_CR_SETTLE;
      end
      S_CR_SETTLE: begin
        cmdValid = 1'b1; op = OP_WAIT; cmdArg = WAIT_LONG;
        if (cmdDone) nxt = S_CR_WAIT;
      end
      S_CR_WAIT: begin
        cmdValid = 1'b1; op = OP_WAIT; cmdArg = WAIT_CR;
        if (cmdDone) nxt = S_CR_READ;
      end
      S_CR_READ: begin
        cmdValid = 1'b1; op = OP_STATUS;
        if (cmdDone) begin
          if (stsErr)          nxt = S_FIN_WAIT;
          else if (crAll)      nxt = S_EQ_PAT;
          else if (atMaxSwing) nxt = S_FIN_WAIT;
          else if (sameVolt && (tries == TRY_W'(CR_TRY_LIMIT - 1))) nxt = S_FIN_WAIT;
          else begin
            st.incTries   = sameVolt;
            st.clrTries   = !sameVolt;
            st.savePrev   = 1'b1;
            st.loadMerged = 1'b1;
            nxt = S_CR_ADJ;
          end
        end
      end
      S_CR_ADJ: begin
        cmdValid = 1'b1; op = OP_DRIVE; cmdArg = ARG_W'(drive);
        if (cmdDone) nxt = S_CR_WAIT;
      end
      S_EQ_PAT: begin
        cmdValid = 1'b1; op = OP_PATTERN; cmdArg = tp3Ok ? 8'd3 : 8'd2;
        if (cmdDone) begin
          st.clrTries = 1'b1;
          nxt = S_EQ_WAIT;
        end
      end
      S_EQ_WAIT: begin
        cmdValid = 1'b1; op = OP_WAIT; cmdArg = WAIT_EQ;
        if (cmdDone) nxt = S_EQ_READ;
      end
      S_EQ_READ: begin
        cmdValid = 1'b1; op = OP_STATUS;
        if (cmdDone) begin
          if (stsErr) nxt = S_FIN_WAIT;
          else if (eqAll) begin
            passSet = 1'b1;
            nxt = S_FIN_WAIT;
          end
          else if (tries > TRY_W'(EQ_TRY_LIMIT)) nxt = S_FIN_WAIT;
          else begin
            st.loadMerged = 1'b1;
            nxt = S_EQ_ADJ;
          end
        end
      end
      S_EQ_ADJ: begin
        cmdValid = 1'b1; op = OP_DRIVE; cmdArg = ARG_W'(drive);
        if (cmdDone) begin
          st.incTries = 1'b1;
          nxt = S_EQ_WAIT;
        end
      end
      S_FIN_WAIT: begin
        cmdValid = 1'b1; op = OP_WAIT; cmdArg = WAIT_LONG;
        if (cmdDone) nxt = S_FIN_PAT;
      end
      S_FIN_PAT: begin
        cmdValid = 1'b1; op = OP_PATTERN; cmdArg = 8'd0;
        if (cmdDone) nxt = S_FIN_CMP;
      end
      S_FIN_CMP: begin
        cmdValid = 1'b1; op = OP_COMPLETE;
        if (cmdDone) nxt = S_DONE;
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      passReg <= 1'b0;
    end else begin
      state <= nxt;
      if (passClr)      passReg <= 1'b0;
      else if (passSet) passReg <= 1'b1;
    end
  end

  assign cmdOp = op;
  assign done  = (state == S_DONE);
  assign pass  = passReg;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdDone |=> cmdValid && $stable(cmdOp) && $stable(cmdArg));  // R11
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !cmdValid);  // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R10
  AST_START_OPENS_CR: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) && start |=> cmdValid && (cmdOp == 3'd1) && (cmdArg == 8'd1));  // R2
  AST_ZERO_DRIVE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CR_ZERO) |-> (cmdArg == '0));  // R2
endmodule

// File: rtl/dp_link_trainer.sv
module dp_link_trainer
  import lt_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LVL_W = 2,
  parameter int CR_TRY_LIMIT = 5,
  parameter int EQ_TRY_LIMIT = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [1:0]             laneCount,
  input  logic                   tp3Ok,
  output logic                   cmdValid,
  output logic [2:0]             cmdOp,
  output logic [ARG_W-1:0]       cmdArg,
  input  logic                   cmdDone,
  input  logic                   stsErr,
  input  logic [LANES-1:0]       stsCrOk,
  input  logic [LANES-1:0]       stsEqOk,
  input  logic [LANES*LVL_W-1:0] stsSwing,
  input  logic [LANES*LVL_W-1:0] stsPreEmph,
  output logic                   done,
  output logic                   pass
);
  localparam int DRV_W   = 2 * LVL_W + 2;
  localparam int TRY_MAX = ((CR_TRY_LIMIT > EQ_TRY_LIMIT) ? CR_TRY_LIMIT : EQ_TRY_LIMIT) + 1;
  localparam int TRY_W   = $clog2(TRY_MAX + 1);

  strobe_t          st;
  logic [DRV_W-1:0] drive;
  logic             crAll, eqAll, atMaxSwing, sameVolt;
  logic [TRY_W-1:0] tries;

  lt_datapath #(
    .LANES(LANES), .LVL_W(LVL_W), .TRY_W(TRY_W), .EQ_TRY_LIMIT(EQ_TRY_LIMIT)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .st(st), .laneCount(laneCount),
    .stsCrOk(stsCrOk), .stsEqOk(stsEqOk), .stsSwing(stsSwing), .stsPreEmph(stsPreEmph),
    .drive(drive), .crAll(crAll), .eqAll(eqAll), .atMaxSwing(atMaxSwing),
    .sameVolt(sameVolt), .tries(tries)
  );

  lt_control #(
    .DRV_W(DRV_W), .TRY_W(TRY_W), .CR_TRY_LIMIT(CR_TRY_LIMIT), .EQ_TRY_LIMIT(EQ_TRY_LIMIT)
  ) i_control (
    .clk(clk), .rstN(rstN), .start(start), .tp3Ok(tp3Ok), .cmdDone(cmdDone),
    .stsErr(stsErr), .crAll(crAll), .eqAll(eqAll), .atMaxSwing(atMaxSwing),
    .sameVolt(sameVolt), .tries(tries), .drive(drive), .st(st),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg), .done(done), .pass(pass)
  );
endmodule

// File: tb/test_dp_link_trainer.sv
module test_dp_link_trainer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] laneCount = 2'd2;
  logic       tp3Ok = 1'b0;
  logic       cmdValid;
  logic [2:0] cmdOp;
  logic [7:0] cmdArg;
  logic       cmdDone = 1'b0;
  logic       stsErr = 1'b0;
  logic [3:0] stsCrOk = '0, stsEqOk = '0;
  logic [7:0] stsSwing = '0, stsPreEmph = '0;
  logic       done, pass;

  always #5 clk = ~clk;

  dp_link_trainer i_dp_link_trainer (
    .clk(clk), .rstN(rstN), .start(start), .laneCount(laneCount), .tp3Ok(tp3Ok),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg), .cmdDone(cmdDone),
    .stsErr(stsErr), .stsCrOk(stsCrOk), .stsEqOk(stsEqOk), .stsSwing(stsSwing),
    .stsPreEmph(stsPreEmph), .done(done), .pass(pass)
  );

  typedef struct packed {
    logic       err;
    logic [3:0] cr;
    logic [3:0] eq;
    logic [7:0] sw;
    logic [7:0] pe;
  } sts_t;

  typedef struct {
    logic [2:0] op;
    logic [7:0] arg;
    string      req;
  } exp_t;

  exp_t  expQ[$];
  sts_t  feedQ[$];
  sts_t  scen[$];
  int    checks = 0;
  int    fails = 0;
  bit    expPass;
  bit    doneSeen;
  exp_t  e;
  sts_t  fs;
  string scenName;

  function automatic sts_t mk(logic err, logic [3:0] cr, logic [3:0] eq,
                              logic [7:0] sw, logic [7:0] pe);
    sts_t s;
    s.err = err; s.cr = cr; s.eq = eq; s.sw = sw; s.pe = pe;
    return s;
  endfunction

  function automatic void push(logic [2:0] op, logic [7:0] arg, string req);
    exp_t x;
    x.op = op; x.arg = arg; x.req = req;
    expQ.push_back(x);
  endfunction

  // R4 model: maximum over active lanes, flag at level 3
  function automatic logic [5:0] mergeReq(sts_t s, int n);
    int v = 0;
    int p = 0;
    for (int i = 0; i < n; i++) begin
      if (int'(s.sw[2*i +: 2]) > v) v = int'(s.sw[2*i +: 2]);
      if (int'(s.pe[2*i +: 2]) > p) p = int'(s.pe[2*i +: 2]);
    end
    return {p == 3, 2'(p), v == 3, 2'(v)};
  endfunction

  function automatic bit allSet(logic [3:0] f, int n);
    for (int i = 0; i < n; i++) if (!f[i]) return 1'b0;
    return 1'b1;
  endfunction

  // Builds the expected command stream from the requirements
  task automatic model(int n, bit tp3);
    logic [5:0] drv = '0;
    int   prev = 4;
    int   tries = 0;
    int   k = 0;
    bit   crPass = 0;
    bit   eqPass = 0;
    sts_t s;
    push(3'd1, 8'd1, "R2");
    push(3'd2, 8'd0, "R2");
    push(3'd4, 8'd0, "R2");
    while (1) begin
      push(3'd4, 8'd1, "R2");
      push(3'd3, 8'd0, "R2");
      s = (k < scen.size()) ? scen[k] : '0; k++;
      if (s.err) break;                              // R9
      if (allSet(s.cr, n)) begin crPass = 1; break; end  // R3
      if (drv[2]) break;                             // R5
      if (int'(drv[1:0]) == prev) begin              // R6
        tries++;
        if (tries == 5) break;
      end else tries = 0;
      prev = int'(drv[1:0]);
      drv = mergeReq(s, n);
      push(3'd2, {2'b00, drv}, "R4");
    end
    if (crPass) begin
      push(3'd1, tp3 ? 8'd3 : 8'd2, "R7");
      tries = 0;
      while (1) begin
        push(3'd4, 8'd2, "R7");
        push(3'd3, 8'd0, "R7");
        s = (k < scen.size()) ? scen[k] : '0; k++;
        if (s.err) break;                            // R9
        if (allSet(s.eq, n)) begin eqPass = 1; break; end
        if (tries > 5) break;                        // R8
        drv = mergeReq(s, n);
        push(3'd2, {2'b00, drv}, "R8");
        tries++;
      end
    end
    push(3'd4, 8'd0, "R10");
    push(3'd1, 8'd0, "R10");
    push(3'd5, 8'd0, "R10");
    expPass = crPass && eqPass;
  endtask

  // Monitor and responder: scores commands, answers them, checks the end
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin
        checks++;
        if (pass !== expPass) begin
          fails++;
          $display("FAIL R10 %s: pass=%0b expected %0b", scenName, pass, expPass);
        end
        checks++;
        if (expQ.size() != 0) begin
          fails++;
          $display("FAIL R10 %s: commands missing before done: actual 0 expected %0d",
                   scenName, expQ.size());
        end
        cmdDone = 1'b0;
        doneSeen = 1'b1;
      end else if (cmdDone) begin
        cmdDone = 1'b0;
      end else if (cmdValid) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R11 %s: unexpected command op=%0d arg=%0h expected none",
                   scenName, cmdOp, cmdArg);
        end else begin
          e = expQ.pop_front();
          if (cmdOp !== e.op || cmdArg !== e.arg) begin
            fails++;
            $display("FAIL %s %s: op=%0d arg=%0h expected op=%0d arg=%0h",
                     e.req, scenName, cmdOp, cmdArg, e.op, e.arg);
          end
        end
        if (cmdOp == 3'd3) begin
          fs = (feedQ.size() != 0) ? feedQ.pop_front() : '0;
          stsErr = fs.err; stsCrOk = fs.cr; stsEqOk = fs.eq;
          stsSwing = fs.sw; stsPreEmph = fs.pe;
        end
        cmdDone = 1'b1;
      end
    end
  end

  task automatic runScenario(string name, logic [1:0] lc, bit tp3);
    int n = (lc == 2'd0) ? 1 : (lc == 2'd1) ? 2 : 4;
    scenName = name;
    expQ.delete();
    feedQ = scen;
    model(n, tp3);
    laneCount = lc;
    tp3Ok = tp3;
    doneSeen = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < 4000 && !doneSeen; c++) @(negedge clk);
    if (!doneSeen) begin
      checks++; fails++;
      $display("FAIL R10 %s: done not seen, actual 0 expected 1", name);
    end
    repeat (3) @(negedge clk);
    scen.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: idle after reset without start
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      checks++;
      if (cmdValid !== 1'b0 || done !== 1'b0) begin
        fails++;
        $display("FAIL R1: cmdValid=%0b done=%0b expected 0 0", cmdValid, done);
      end
    end

    // R3 R7 R10: four lanes, immediate success, pattern 3
    scen.push_back(mk(0, 4'hF, 4'h0, 8'h00, 8'h00));
    scen.push_back(mk(0, 4'hF, 4'hF, 8'h00, 8'h00));
    runScenario("quick4", 2'd2, 1'b1);

    // R3 R4 R7: two lanes, inactive lanes carry large requests and stray flags
    scen.push_back(mk(0, 4'b0001, 4'h0, {2'd3, 2'd0, 2'd2, 2'd1}, {2'd0, 2'd3, 2'd1, 2'd0}));
    scen.push_back(mk(0, 4'b0011, 4'h0, 8'h00, 8'h00));
    scen.push_back(mk(0, 4'hF, 4'b1101, {2'd3, 2'd3, 2'd1, 2'd0}, {2'd0, 2'd0, 2'd0, 2'd3}));
    scen.push_back(mk(0, 4'hF, 4'b0011, 8'h00, 8'h00));
    runScenario("merge2", 2'd1, 1'b0);

    // R5: one lane hits the swing limit
    scen.push_back(mk(0, 4'b1110, 4'h0, 8'h03, 8'h00));
    scen.push_back(mk(0, 4'b1110, 4'h0, 8'h03, 8'h00));
    runScenario("maxswing1", 2'd0, 1'b1);

    // R6: constant request, repeat counter ends clock recovery
    for (int i = 0; i < 10; i++) scen.push_back(mk(0, 4'h0, 4'h0, 8'h55, 8'h00));
    runScenario("repeat4", 2'd3, 1'b0);

    // R8: equalisation never settles
    scen.push_back(mk(0, 4'hF, 4'h0, 8'h00, 8'h00));
    for (int i = 0; i < 9; i++) scen.push_back(mk(0, 4'hF, 4'b0111, 8'h24, 8'h11));
    runScenario("eqlimit4", 2'd2, 1'b1);

    // R9: status error during clock recovery skips equalisation
    scen.push_back(mk(1, 4'hF, 4'hF, 8'h00, 8'h00));
    runScenario("crerr2", 2'd1, 1'b1);

    // R9: status error during equalisation
    scen.push_back(mk(0, 4'hF, 4'h0, 8'h00, 8'h00));
    scen.push_back(mk(0, 4'hF, 4'h0, 8'h05, 8'h00));
    scen.push_back(mk(1, 4'hF, 4'hF, 8'h00, 8'h00));
    runScenario("eqerr4", 2'd2, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule